// File: doc/BRIEF.md
# Region Reuse Bypass Decision Table

This block keeps a small direct-mapped table of saturating access counters, one per 1 KB memory region. Every data access looks up its region's entry alongside the cache lookup. If the entry is present, its counter is bumped. If it is absent, the entry is allocated. In both cases the count seen before the access is captured for a possible miss.

When the cache reports a miss, the block is given the missing address and the address of the line that would be evicted. It compares the captured count of the missing region against the victim region's count. On that conflict the victim's count is decayed by one. If the missing region is used less than the region it would displace, the block tells the cache controller to bypass the fill. It also gives a fetch-size hint: a whole line when the missing region's spatial bit is set, otherwise a single 8-byte element.

A neighbouring bypass buffer sets or clears the spatial bit through a dedicated port. A parameter chooses how a new entry's counter is seeded. In first-level mode it starts at zero. In second-level mode it takes the victim's count at the first miss after allocation.

Top module: `region_bypass_table`

## Requirements
- R1: After reset every table entry is invalid and `byp_valid` is low. A miss decided against an empty table never bypasses.
- R2: An access whose region (address bits above bit 9) has no matching entry allocates one with counter 0 and spatial bit 0. A miss for that region that directly follows the allocating access does not bypass, because the pre-access count is unknown and is taken as all ones.
- R3: An access whose region has a matching entry increments that entry's counter by one. The count before the increment becomes ctr1 for the next miss request.
- R4: Each cycle with `miss_valid` high produces exactly one result, with `byp_valid` high in the following cycle, including misses on back-to-back cycles. No result appears in any other cycle.
- R5: Let ctr2 be the victim entry's count and d be ctr2 minus one, floored at 0. When ctr1 is known and the victim entry is present, `byp_take` is 1 exactly when ctr1 − 1 < d in signed arithmetic. This means ctr1 = 0 always bypasses.
- R6: Every miss whose victim entry is present lowers the victim counter by one, holding at 0.
- R7: ctr1 is known only when the most recent access was to the missing region, hit an existing entry, and has not yet been consumed by an earlier miss. Without a known ctr1, or when `vict_valid` is 0 or the victim region has no entry, `byp_take` is 0.
- R8: In second-level mode, when the missing region was allocated by the access just before and the victim entry is present, the missing region's counter is set to the victim's count before its decrement.
- R9: The table index is the low log2(ENTRIES) bits of the region number, and the remaining region bits form the tag. Allocating a region whose index holds a different tag replaces that entry, so the old region then reads as absent.
- R10: A `sp_valid` pulse writes `sp_set` into the spatial bit of the entry named by `sp_region`, if that entry is present. `byp_full` is 1 (fetch the whole line) only when the result bypasses and the missing region's spatial bit is 1. Otherwise it is 0 (fetch one 8-byte element).
- R11: A counter that reaches 2^CTR_W − 1 stays there on further accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A data access happens this cycle |
| acc_addr | input | ADDR_W | Access address |
| miss_valid | input | 1 | The cache reports a miss this cycle |
| miss_addr | input | ADDR_W | Address that missed |
| vict_addr | input | ADDR_W | Address of the line that would be evicted |
| vict_valid | input | 1 | The evicted slot holds a valid line |
| sp_valid | input | 1 | Spatial bit write strobe from the bypass buffer |
| sp_region | input | ADDR_W−10 | Region number whose spatial bit is written |
| sp_set | input | 1 | Value written to the spatial bit |
| byp_valid | output | 1 | Result strobe, one cycle after a miss |
| byp_take | output | 1 | 1: the fill bypasses the cache |
| byp_full | output | 1 | 1: request the whole line, 0: request one 8-byte element |

## Verification
The decision for a miss presented in one cycle is due in the next cycle, so the bench tags every expected result with the cycle number in which it must appear. The bench compares the result at the falling edge of exactly that cycle. A strobe in any other cycle counts as an error. Counter effects of accesses and decays are visible only through later decisions, so each expectation is computed from a bench-side account of the counters and of the captured pre-access count. That account is updated in the same cycle order the block uses. A second instance in second-level seeding mode receives the same stimulus and is scored against its own expectations.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  typedef enum logic {
    INIT_ZERO   = 1'b0,
    INIT_VICTIM = 1'b1
  } rbt_init_e;

  typedef struct packed {
    logic take;
    logic full;
  } rbt_verdict_t;
endpackage

// File: rtl/rbt_store.sv
module rbt_store #(
  parameter int IDX_W = 9,
  parameter int TAG_W = 13,
  parameter int CTR_W = 8,
  parameter rbt_pkg::rbt_init_e INIT_MODE = rbt_pkg::INIT_ZERO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic [TAG_W-1:0] acc_tag,
  input  logic             miss_valid,
  input  logic [IDX_W-1:0] miss_idx,
  input  logic [TAG_W-1:0] miss_tag,
  input  logic             miss_fresh,
  input  logic             vict_valid,
  input  logic [IDX_W-1:0] vict_idx,
  input  logic [TAG_W-1:0] vict_tag,
  input  logic             sp_valid,
  input  logic [IDX_W-1:0] sp_idx,
  input  logic [TAG_W-1:0] sp_tag,
  input  logic             sp_set,
  output logic             acc_hit,
  output logic [CTR_W-1:0] acc_ctr,
  output logic             vict_hit,
  output logic [CTR_W-1:0] vict_ctr,
  output logic             miss_hit,
  output logic             miss_sp
);
  localparam int ENTRIES = 2 ** IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  function automatic logic [CTR_W-1:0] sat_inc(input logic [CTR_W-1:0] v);
    return (v == CTR_MAX) ? v : v + CTR_W'(1);
  endfunction

  function automatic logic [CTR_W-1:0] sat_dec(input logic [CTR_W-1:0] v);
    return (v == '0) ? v : v - CTR_W'(1);
  endfunction

  logic             ent_v   [ENTRIES];
  logic [TAG_W-1:0] ent_tag [ENTRIES];
  logic [CTR_W-1:0] ent_ctr [ENTRIES];
  logic             ent_sp  [ENTRIES];

  logic sp_hit;
  logic vict_dec_ev;
  logic seed_ev;

  assign acc_hit  = ent_v[acc_idx] && (ent_tag[acc_idx] == acc_tag);
  assign acc_ctr  = ent_ctr[acc_idx];
  assign vict_hit = vict_valid && ent_v[vict_idx] && (ent_tag[vict_idx] == vict_tag);
  assign vict_ctr = ent_ctr[vict_idx];
  assign miss_hit = ent_v[miss_idx] && (ent_tag[miss_idx] == miss_tag);
  assign miss_sp  = ent_sp[miss_idx];
  assign sp_hit   = ent_v[sp_idx] && (ent_tag[sp_idx] == sp_tag);

  assign vict_dec_ev = miss_valid && vict_hit;

  generate
    if (INIT_MODE == rbt_pkg::INIT_VICTIM) begin : g_seed_victim
      assign seed_ev = miss_valid && miss_fresh && vict_hit && miss_hit;
    end else begin : g_seed_zero
      assign seed_ev = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        ent_v[e]   <= 1'b0;
        ent_tag[e] <= '0;
        ent_ctr[e] <= '0;
        ent_sp[e]  <= 1'b0;
      end
    end else begin
      if (vict_dec_ev) ent_ctr[vict_idx] <= sat_dec(vict_ctr);
      if (seed_ev)     ent_ctr[miss_idx] <= vict_ctr;
      if (acc_valid) begin
        if (acc_hit) begin
          ent_ctr[acc_idx] <= sat_inc(acc_ctr);
        end else begin
          ent_v[acc_idx]   <= 1'b1;
          ent_tag[acc_idx] <= acc_tag;
          ent_ctr[acc_idx] <= '0;
          ent_sp[acc_idx]  <= 1'b0;
        end
      end
      if (sp_valid && sp_hit) ent_sp[sp_idx] <= sp_set;
    end
  end

  // R11
  ctr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |=> (ent_ctr[$past(acc_idx)] != '0));

  // R6
  vict_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vict_dec_ev && !(acc_valid && acc_idx == vict_idx) && !(seed_ev && miss_idx == vict_idx))
    |=> (ent_ctr[$past(vict_idx)] <= $past(vict_ctr)));

  // R2
  alloc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit) |=> (ent_v[$past(acc_idx)] && ent_ctr[$past(acc_idx)] == '0));
endmodule

// File: rtl/rbt_latch.sv
module rbt_latch #(
  parameter int RGN_W = 22,
  parameter int CTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [RGN_W-1:0] acc_rgn,
  input  logic             acc_hit,
  input  logic [CTR_W-1:0] acc_ctr,
  input  logic             miss_valid,
  input  logic [RGN_W-1:0] miss_rgn,
  output logic             c1_known,
  output logic             c1_fresh,
  output logic [CTR_W-1:0] c1_val
);
  logic             lat_ok;
  logic             lat_new;
  logic [RGN_W-1:0] lat_rgn;
  logic [CTR_W-1:0] lat_ctr;
  logic             same_rgn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_ok  <= 1'b0;
      lat_new <= 1'b0;
      lat_rgn <= '0;
      lat_ctr <= '0;
    end else if (acc_valid) begin
      lat_ok  <= 1'b1;
      lat_new <= !acc_hit;
      lat_rgn <= acc_rgn;
      lat_ctr <= acc_ctr;
    end else if (miss_valid) begin
      lat_ok <= 1'b0;
    end
  end

  assign same_rgn = lat_ok && (lat_rgn == miss_rgn);
  assign c1_known = same_rgn && !lat_new;
  assign c1_fresh = same_rgn && lat_new;
  assign c1_val   = c1_known ? lat_ctr : '1;

  // R2
  lat_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit) |=> !c1_known);

  // R7
  lat_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !acc_valid) |=> (!c1_known && !c1_fresh));
endmodule

// File: rtl/rbt_decide.sv
module rbt_decide #(
  parameter int CTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic             c1_known,
  input  logic [CTR_W-1:0] c1_val,
  input  logic             vict_hit,
  input  logic [CTR_W-1:0] vict_ctr,
  input  logic             miss_hit,
  input  logic             miss_sp,
  output logic             byp_valid,
  output logic             byp_take,
  output logic             byp_full
);
  import rbt_pkg::*;

  function automatic logic want_bypass(input logic [CTR_W-1:0] c1,
                                       input logic [CTR_W-1:0] c2);
    logic [CTR_W-1:0] d;
    d = (c2 == '0) ? c2 : c2 - CTR_W'(1);
    return {1'b0, c1} < ({1'b0, d} + {{CTR_W{1'b0}}, 1'b1});
  endfunction

  logic [CTR_W-1:0] c2_sel;
  logic             take_now;
  rbt_verdict_t     vd_d, vd_q;
  logic             vld_q;

  assign c2_sel   = vict_hit ? vict_ctr : '0;
  assign take_now = c1_known && vict_hit && want_bypass(c1_val, c2_sel);
  assign vd_d.take = take_now;
  assign vd_d.full = take_now && miss_hit && miss_sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vd_q  <= '0;
    end else begin
      vld_q <= miss_valid;
      vd_q  <= miss_valid ? vd_d : '0;
    end
  end

  assign byp_valid = vld_q;
  assign byp_take  = vd_q.take;
  assign byp_full  = vd_q.full;

  // R4
  result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> byp_valid);

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |=> !byp_valid);

  // R7
  take_needs_info_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_take |-> $past(c1_known && vict_hit));

  // R10
  full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_full |-> $past(miss_hit && miss_sp));
endmodule

// File: rtl/region_bypass_table.sv
module region_bypass_table #(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 10,
  parameter int ENTRIES    = 512,
  parameter int CTR_W      = 8,
  parameter rbt_pkg::rbt_init_e INIT_MODE = rbt_pkg::INIT_ZERO
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_valid,
  input  logic [ADDR_W-1:0]            acc_addr,
  input  logic                         miss_valid,
  input  logic [ADDR_W-1:0]            miss_addr,
  input  logic [ADDR_W-1:0]            vict_addr,
  input  logic                         vict_valid,
  input  logic                         sp_valid,
  input  logic [ADDR_W-REGION_LSB-1:0] sp_region,
  input  logic                         sp_set,
  output logic                         byp_valid,
  output logic                         byp_take,
  output logic                         byp_full
);
  localparam int RGN_W = ADDR_W - REGION_LSB;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = RGN_W - IDX_W;

  logic [RGN_W-1:0] acc_rgn, miss_rgn, vict_rgn;
  logic             unused_offsets;

  assign acc_rgn  = acc_addr[ADDR_W-1:REGION_LSB];
  assign miss_rgn = miss_addr[ADDR_W-1:REGION_LSB];
  assign vict_rgn = vict_addr[ADDR_W-1:REGION_LSB];
  assign unused_offsets = ^{acc_addr[REGION_LSB-1:0], miss_addr[REGION_LSB-1:0],
                            vict_addr[REGION_LSB-1:0]};

  logic             acc_hit, vict_hit, miss_hit, miss_sp;
  logic [CTR_W-1:0] acc_ctr, vict_ctr, c1_val;
  logic             c1_known, c1_fresh;

  rbt_store #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .CTR_W(CTR_W), .INIT_MODE(INIT_MODE)
  ) store_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_idx    (acc_rgn[IDX_W-1:0]),
    .acc_tag    (acc_rgn[RGN_W-1:IDX_W]),
    .miss_valid (miss_valid),
    .miss_idx   (miss_rgn[IDX_W-1:0]),
    .miss_tag   (miss_rgn[RGN_W-1:IDX_W]),
    .miss_fresh (c1_fresh),
    .vict_valid (vict_valid),
    .vict_idx   (vict_rgn[IDX_W-1:0]),
    .vict_tag   (vict_rgn[RGN_W-1:IDX_W]),
    .sp_valid   (sp_valid),
    .sp_idx     (sp_region[IDX_W-1:0]),
    .sp_tag     (sp_region[RGN_W-1:IDX_W]),
    .sp_set     (sp_set),
    .acc_hit    (acc_hit),
    .acc_ctr    (acc_ctr),
    .vict_hit   (vict_hit),
    .vict_ctr   (vict_ctr),
    .miss_hit   (miss_hit),
    .miss_sp    (miss_sp)
  );

  rbt_latch #(.RGN_W(RGN_W), .CTR_W(CTR_W)) latch_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_rgn    (acc_rgn),
    .acc_hit    (acc_hit),
    .acc_ctr    (acc_ctr),
    .miss_valid (miss_valid),
    .miss_rgn   (miss_rgn),
    .c1_known   (c1_known),
    .c1_fresh   (c1_fresh),
    .c1_val     (c1_val)
  );

  rbt_decide #(.CTR_W(CTR_W)) decide_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .c1_known   (c1_known),
    .c1_val     (c1_val),
    .vict_hit   (vict_hit),
    .vict_ctr   (vict_ctr),
    .miss_hit   (miss_hit),
    .miss_sp    (miss_sp),
    .byp_valid  (byp_valid),
    .byp_take   (byp_take),
    .byp_full   (byp_full)
  );
endmodule

// File: tb/region_bypass_table_tb_top.sv
module region_bypass_table_tb_top;
  import rbt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 512;
  localparam int MAXC       = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid, miss_valid, vict_valid, sp_valid, sp_set;
  logic [31:0] acc_addr, miss_addr, vict_addr;
  logic [21:0] sp_region;
  logic        v0, t0, f0, v1, t1, f1;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_bypass_table dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .vict_addr(vict_addr),
    .vict_valid(vict_valid), .sp_valid(sp_valid), .sp_region(sp_region),
    .sp_set(sp_set), .byp_valid(v0), .byp_take(t0), .byp_full(f0));

  region_bypass_table #(.INIT_MODE(INIT_VICTIM)) dut_l2_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .vict_addr(vict_addr),
    .vict_valid(vict_valid), .sp_valid(sp_valid), .sp_region(sp_region),
    .sp_set(sp_set), .byp_valid(v1), .byp_take(t1), .byp_full(f1));

  typedef struct {
    int    due;
    bit    take;
    bit    full;
    string req;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  // bench account of the table, [0] first-level seeding, [1] second-level seeding
  bit m_v   [2][N];
  int m_tag [2][N];
  int m_ctr [2][N];
  bit m_sp  [2][N];
  bit l_ok  [2];
  bit l_new [2];
  int l_rgn [2];
  int l_c1  [2];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] addr_of(input int r);
    return (32'(r) << 10) | 32'h1a8;
  endfunction

  function automatic int floor_dec(input int c);
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic score(input int m, input bit v, input bit t, input bit f);
    exp_t e;
    bit   due_now;
    due_now = (m == 0) ? (q0.size() > 0 && q0[0].due == cyc)
                       : (q1.size() > 0 && q1[0].due == cyc);
    if (due_now) begin
      e = (m == 0) ? q0.pop_front() : q1.pop_front();
      checks++;
      if (!v) begin
        fails++;
        $display("FAIL %s: dut%0d result strobe missing, actual valid=%0d expected valid=1",
                 e.req, m, v);
      end else if (t != e.take || f != e.full) begin
        fails++;
        $display("FAIL %s: dut%0d actual take=%0d full=%0d expected take=%0d full=%0d",
                 e.req, m, t, f, e.take, e.full);
      end
    end else if (v) begin
      checks++;
      fails++;
      $display("FAIL R4: dut%0d strobe at cycle %0d, actual valid=1 expected valid=0", m, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      score(0, v0, t0, f0);
      score(1, v1, t1, f1);
    end
  end

  task automatic idle_inputs();
    acc_valid = 1'b0; miss_valid = 1'b0; vict_valid = 1'b0; sp_valid = 1'b0;
    sp_set = 1'b0; acc_addr = '0; miss_addr = '0; vict_addr = '0; sp_region = '0;
  endtask

  task automatic rest();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic access(input int r);
    int i, t;
    @(negedge clk);
    idle_inputs();
    acc_valid = 1'b1;
    acc_addr  = addr_of(r);
    i = r % N; t = r / N;
    for (int m = 0; m < 2; m++) begin
      bit hit;
      hit = m_v[m][i] && m_tag[m][i] == t;
      l_ok[m] = 1; l_rgn[m] = r; l_new[m] = !hit;
      if (hit) begin
        l_c1[m] = m_ctr[m][i];
        if (m_ctr[m][i] < MAXC) m_ctr[m][i]++;
      end else begin
        m_v[m][i] = 1; m_tag[m][i] = t; m_ctr[m][i] = 0; m_sp[m][i] = 0;
      end
    end
  endtask

  task automatic spatial(input int r, input bit s);
    @(negedge clk);
    idle_inputs();
    sp_valid = 1'b1; sp_region = 22'(r); sp_set = s;
    for (int m = 0; m < 2; m++)
      if (m_v[m][r % N] && m_tag[m][r % N] == r / N) m_sp[m][r % N] = s;
  endtask

  task automatic miss(input int mr, input int vr, input bit vv, input string req);
    int mi, mt, vi, vt;
    @(negedge clk);
    idle_inputs();
    miss_valid = 1'b1; miss_addr = addr_of(mr);
    vict_valid = vv;   vict_addr = addr_of(vr);
    mi = mr % N; mt = mr / N; vi = vr % N; vt = vr / N;
    for (int m = 0; m < 2; m++) begin
      bit   vhit, mhit, known, fresh;
      int   c2;
      exp_t e;
      vhit  = vv && m_v[m][vi] && m_tag[m][vi] == vt;
      mhit  = m_v[m][mi] && m_tag[m][mi] == mt;
      known = l_ok[m] && l_rgn[m] == mr && !l_new[m];
      fresh = l_ok[m] && l_rgn[m] == mr && l_new[m];
      c2    = vhit ? m_ctr[m][vi] : 0;
      e.due  = cyc + 1;
      e.take = vhit && known && (l_c1[m] - 1 < floor_dec(c2));
      e.full = e.take && mhit && m_sp[m][mi];
      e.req  = (m == 0) ? req : {"R8/", req};
      if (m == 0) q0.push_back(e); else q1.push_back(e);
      if (vhit) m_ctr[m][vi] = floor_dec(c2);
      if (m == 1 && fresh && vhit && mhit) m_ctr[m][mi] = c2;
      l_ok[m] = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: no strobe during or right after reset
    checks++;
    if (v0 !== 1'b0 || v1 !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset strobe actual=%0d/%0d expected=0/0", v0, v1);
    end
    rst_n = 1'b1;

    miss(5, 6, 1, "R1");                       // empty table
    repeat (6) access(6);                      // region 6 count reaches 5
    access(5); miss(5, 6, 1, "R2");            // freshly allocated: no bypass
    access(5); miss(5, 6, 1, "R5");            // ctr1 = 0 against hotter victim
    spatial(5, 1); access(5); miss(5, 6, 1, "R10");
    access(5); miss(5, 6, 1, "R5");            // boundary: equal after decay
    miss(5, 6, 1, "R7");                       // capture already consumed
    access(5); miss(5, 6, 0, "R7");            // victim slot not valid
    access(5); miss(5, 6, 1, "R4"); miss(5, 6, 1, "R4");
    for (int k = 0; k < 6; k++) begin
      access(5); miss(5, 6, 1, "R6");          // victim decays to zero
    end
    access(6); repeat (3) access(42); miss(42, 6, 1, "R6");
    repeat (3) access(45); repeat (5) access(46); access(45);
    miss(45, 46, 1, "R3");
    spatial(5, 0); repeat (30) access(6); access(5); miss(5, 6, 1, "R10");
    repeat (300) access(40); repeat (101) access(41); miss(41, 40, 1, "R11");
    access(517); access(517); repeat (2) access(44); miss(44, 5, 1, "R9");
    repeat (4) rest();

    // R4: every expected result was delivered
    checks++;
    if (q0.size() != 0 || q1.size() != 0) begin
      fails++;
      $display("FAIL R4: pending results actual=%0d/%0d expected=0/0", q0.size(), q1.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule